// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It accepts one access request at a time. Each request carries a bank, a row, a column, a read/write flag and an auto-precharge flag. The block turns the request into the command sequence on the chip-select, row strobe, column strobe, write-enable, bank and address pins. It keeps an open/idle flag and the open row for every bank. A request that hits the open row goes straight to the column command. A request to a different row first closes the bank. A request to an idle bank first opens it.

All timing limits are module parameters in clock cycles. The defaults are derived at elaboration from nanosecond limits and a clock period (5 ns), rounding up. The sequencer holds each command until every limit that applies to it has elapsed, and then issues it in the first cycle allowed. After reset, the block programs the mode register once before it accepts any request. Refresh scheduling and the data path are separate blocks. All accesses are assumed to use a burst length of one.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted the pins show deselect (cs_n high), and req_ready and done are low.
- R2: After reset the first command is a mode register set, encoded (cs_n,ras_n,cas_n,we_n)=0000, with ba=0 and addr=MODE_WORD. No other command appears until at least T_MRD cycles after it.
- R3: Command encodings on (cs_n,ras_n,cas_n,we_n) are: activate 0011, read 0101, write 0100, precharge 0010, idle deselect 1xxx (all ones). Only these patterns, plus 0000, ever appear.
- R4: A request to an idle bank issues activate (ba=bank, addr=row), then the column command exactly T_RCD cycles later. The column command carries addr[COL_W-1:0]=column, addr[10]=auto-precharge flag and all other bits zero.
- R5: A request to the row already open in its bank issues only the column command, with no activate or precharge.
- R6: A request to an open bank with a different row issues precharge (ba=bank, addr=0 so A10 is low), then activate, then the column command. The precharge comes no sooner than T_RAS after that bank's activate and no sooner than T_RDL after its last write.
- R7: Two activates to the same bank are at least T_RC apart, and an activate comes at least T_RP after a precharge of that bank.
- R8: Activates to any two banks are at least T_RRD apart.
- R9: A column command with A10 high leaves the bank idle, so the next request to it issues activate without precharge. That activate waits T_RP after the internal precharge point. The internal precharge point is the latest of: the column command (plus T_RDL for a write), the last write plus T_RDL, and the activate plus T_RAS.
- R10: req_ready is high only while the sequencer is idle and initialised. Each accepted request yields exactly one one-cycle done pulse, in the cycle its column command is on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after the column command |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Target column |
| done | output | 1 | One-cycle pulse with the column command |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Multiplexed row/column address |

## Verification
The bench goes after four corner cases.

- **Row miss right after a write.** A design that ignores write recovery or the minimum active time would precharge too early. The bench measures the gap from the write and from the activate on the pins.
- **Back-to-back activates on different banks.** A design that skips the activate-to-activate spacing would place them closer than T_RRD.
- **Auto-precharged banks.** A design that still treats the bank as open would issue a bare column command. A design that counts T_RP from the column command would reactivate too soon.
- **Full-width column and all-ones row.** These catch address fields packed at the wrong offset or a dropped A10 flag.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_DESEL = 4'b1111
  } cmd_e;

  // nanoseconds -> whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned span;
    int unsigned whole;
    span  = ns * 1000;
    whole = span / clk_ps;
    if (whole * clk_ps < span) whole = whole + 1;
    if (whole == 0) whole = 1;
    return whole;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_bank.sv
module seq_bank #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 6,
  parameter int T_RCD = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_RP  = 3,
  parameter int T_RDL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             pre_ok_o,
  output logic             col_ok_o
);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_RDL = CNT_W'(T_RDL - 1);
  localparam logic [CNT_W-1:0] K_RDL = CNT_W'(T_RDL);
  localparam logic [CNT_W-1:0] K_RP  = CNT_W'(T_RP);

  function automatic logic [CNT_W-1:0] dn(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q;
  logic [CNT_W-1:0] ap_hold, ap_rp;
  logic             col_i;

  assign col_i   = rd_i | wr_i;
  // cycles from this column command to the internal precharge
  assign ap_hold = mx(mx(ras_q, wr_q), wr_i ? K_RDL : '0);
  assign ap_rp   = ap_hold + K_RP - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
    end else begin
      rcd_q <= dn(rcd_q);
      ras_q <= dn(ras_q);
      rc_q  <= dn(rc_q);
      rp_q  <= dn(rp_q);
      wr_q  <= dn(wr_q);
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= L_RCD;
        ras_q  <= L_RAS;
        rc_q   <= L_RC;
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= L_RP;
      end
      if (wr_i && !ap_i) wr_q <= L_RDL;
      if (col_i && ap_i) begin
        open_q <= 1'b0;
        rp_q   <= ap_rp;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = !open_q && (rp_q == '0) && (rc_q == '0);
  assign pre_ok_o = open_q && (ras_q == '0) && (wr_q == '0);
  assign col_ok_o = open_q && (rcd_q == '0);

  // the sequencer above only strobes a bank when the bank says it may
  p_act_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0 && rc_q == '0));
  p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |-> (open_q && ras_q == '0 && wr_q == '0));
  p_col_needs_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (open_q && rcd_q == '0));
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({act_i, pre_i, rd_i, wr_i}) <= 1);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int          ROW_W     = 12,
  parameter int          COL_W     = 9,
  parameter int          BANKS     = 4,
  parameter int          CLK_PS    = 5000,
  parameter int          T_RCD     = ns_to_cyc(15, CLK_PS),
  parameter int          T_RP      = ns_to_cyc(15, CLK_PS),
  parameter int          T_RAS     = ns_to_cyc(40, CLK_PS),
  parameter int          T_RC      = ns_to_cyc(55, CLK_PS),
  parameter int          T_RRD     = ns_to_cyc(10, CLK_PS),
  parameter int          T_RDL     = 2,
  parameter int          T_MRD     = 2,
  parameter logic [11:0] MODE_WORD = 12'h020
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_autopre,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  output logic                     done,
  output logic                     cs_n,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic [$clog2(BANKS)-1:0] ba,
  output logic [ROW_W-1:0]         addr
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int MAXT  = umax(umax(T_RC, T_RAS), umax(T_MRD, T_RRD)) + T_RP + T_RDL + 2;
  localparam int CNT_W = $clog2(MAXT) + 1;
  localparam int AP_BIT = 10;

  typedef enum logic [2:0] {S_MRS, S_MRD, S_IDLE, S_PRE, S_ACT, S_COL} state_e;

  state_e           state_q, state_d;
  cmd_e             cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d, q_bank;
  logic [ROW_W-1:0] addr_q, addr_d, q_row;
  logic [COL_W-1:0] q_col;
  logic             q_wr, q_ap, done_q;
  logic [CNT_W-1:0] mrd_q, rrd_q;

  logic [BANKS-1:0] b_open, b_act_ok, b_pre_ok, b_col_ok;
  logic [BANKS-1:0] s_act, s_pre, s_rd, s_wr;
  logic [ROW_W-1:0] b_row [BANKS];

  // named events for the checks
  logic issue_act, issue_pre, issue_col, accept;
  assign issue_act = (cmd_d == CMD_ACT);
  assign issue_pre = (cmd_d == CMD_PRE);
  assign issue_col = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);
  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;

  function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c, input logic ap);
    logic [ROW_W-1:0] a;
    a = '0;
    a[COL_W-1:0] = c;
    a[AP_BIT] = ap;
    return a;
  endfunction

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    assign s_act[i] = issue_act && (q_bank == BA_W'(i));
    assign s_pre[i] = issue_pre && (q_bank == BA_W'(i));
    assign s_rd[i]  = (cmd_d == CMD_RD) && (q_bank == BA_W'(i));
    assign s_wr[i]  = (cmd_d == CMD_WR) && (q_bank == BA_W'(i));
    seq_bank #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RC(T_RC), .T_RP(T_RP), .T_RDL(T_RDL)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(s_act[i]), .pre_i(s_pre[i]), .rd_i(s_rd[i]), .wr_i(s_wr[i]),
      .ap_i(q_ap), .row_i(q_row),
      .open_o(b_open[i]), .row_o(b_row[i]),
      .act_ok_o(b_act_ok[i]), .pre_ok_o(b_pre_ok[i]), .col_ok_o(b_col_ok[i])
    );
  end

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_DESEL;
    ba_d    = '0;
    addr_d  = '0;
    case (state_q)
      S_MRS: begin
        cmd_d   = CMD_MRS;
        addr_d  = ROW_W'(MODE_WORD);
        state_d = S_MRD;
      end
      S_MRD: if (mrd_q == '0) state_d = S_IDLE;
      S_IDLE: if (req_valid) begin
        if (!b_open[req_bank])                 state_d = S_ACT;
        else if (b_row[req_bank] == req_row)   state_d = S_COL;
        else                                   state_d = S_PRE;
      end
      S_PRE: if (b_pre_ok[q_bank]) begin
        cmd_d   = CMD_PRE;
        ba_d    = q_bank;
        state_d = S_ACT;
      end
      S_ACT: if (b_act_ok[q_bank] && rrd_q == '0) begin
        cmd_d   = CMD_ACT;
        ba_d    = q_bank;
        addr_d  = q_row;
        state_d = S_COL;
      end
      S_COL: if (b_col_ok[q_bank]) begin
        cmd_d   = q_wr ? CMD_WR : CMD_RD;
        ba_d    = q_bank;
        addr_d  = col_addr(q_col, q_ap);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_MRS;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      mrd_q   <= '0;
      rrd_q   <= '0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col   <= '0;
      q_wr    <= 1'b0;
      q_ap    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      done_q  <= issue_col;
      if (cmd_d == CMD_MRS)  mrd_q <= CNT_W'(T_MRD - 1);
      else if (mrd_q != '0)  mrd_q <= mrd_q - 1'b1;
      if (issue_act)         rrd_q <= CNT_W'(T_RRD - 1);
      else if (rrd_q != '0)  rrd_q <= rrd_q - 1'b1;
      if (accept) begin
        q_bank <= req_bank;
        q_row  <= req_row;
        q_col  <= req_col;
        q_wr   <= req_write;
        q_ap   <= req_autopre;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign done = done_q;

  // pin-level gap counters, independent of the issue counters
  logic [CNT_W-1:0] gap_act, gap_mrs;
  logic             mrs_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_act  <= CNT_W'(T_RRD);
      gap_mrs  <= '0;
      mrs_seen <= 1'b0;
    end else begin
      if (cmd_q == CMD_ACT)               gap_act <= CNT_W'(1);
      else if (gap_act < CNT_W'(T_RRD))   gap_act <= gap_act + 1'b1;
      if (cmd_q == CMD_MRS) begin
        gap_mrs  <= CNT_W'(1);
        mrs_seen <= 1'b1;
      end else if (gap_mrs < CNT_W'(T_MRD)) gap_mrs <= gap_mrs + 1'b1;
    end
  end

  p_rrd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> (gap_act >= CNT_W'(T_RRD)));
  p_mrd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_DESEL && cmd_q != CMD_MRS) |-> (mrs_seen && gap_mrs >= CNT_W'(T_MRD)));
  p_done_with_col_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n || (cmd_q inside {CMD_MRS, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD}));
endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int PS    = 5000;
  localparam int E_RCD = (15 * 1000 + PS - 1) / PS;
  localparam int E_RP  = (15 * 1000 + PS - 1) / PS;
  localparam int E_RAS = (40 * 1000 + PS - 1) / PS;
  localparam int E_RC  = (55 * 1000 + PS - 1) / PS;
  localparam int E_RRD = (10 * 1000 + PS - 1) / PS;
  localparam int E_RDL = 2;
  localparam int E_MRD = 2;
  localparam logic [11:0] MODE = 12'h020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ready, done, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;

  always #2 clk = ~clk;

  sdram_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .done(done), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  typedef struct packed { logic [3:0] c; logic [1:0] b; logic [11:0] a; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0, n_req = 0;
  bit finished = 0;
  bit m_open[4];
  logic [11:0] m_row[4];
  int last_act[4], last_wr[4], act_ok_at[4];
  bit col_seen[4];
  int last_any_act = -1000, mrs_cyc = -1000;
  bit first_after_mrs = 1;

  task automatic check(input bit ok, input string tag, input int got, input int want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expected commands and check spacing on the pins
  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    exp_t e;
    int b, pre_at;
    c = {cs_n, ras_n, cas_n, we_n};
    b = int'(ba);
    if (done) n_done++;
    if (c != 4'b1111) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected command", int'(c), 15);
      else begin
        e = exp_q.pop_front();
        check(c == e.c, "R3 command code", int'(c), int'(e.c));
        check(ba == e.b, "R4 bank", int'(ba), int'(e.b));
        check(addr == e.a, "R4 address", int'(addr), int'(e.a));
      end
      if (c != 4'b0000 && first_after_mrs) begin
        first_after_mrs = 0;
        check(cyc - mrs_cyc >= E_MRD, "R2 mode-set gap", cyc - mrs_cyc, E_MRD);
      end
      case (c)
        4'b0000: mrs_cyc = cyc;
        4'b0011: begin
          check(cyc - last_any_act >= E_RRD, "R8 act-act gap", cyc - last_any_act, E_RRD);
          check(cyc - last_act[b] >= E_RC, "R7 same-bank act gap", cyc - last_act[b], E_RC);
          check(cyc >= act_ok_at[b], "R9/R7 act after precharge", cyc, act_ok_at[b]);
          last_act[b] = cyc; last_any_act = cyc; col_seen[b] = 0;
        end
        4'b0010: begin
          check(cyc - last_act[b] >= E_RAS, "R6 pre after act", cyc - last_act[b], E_RAS);
          check(cyc - last_wr[b] >= E_RDL, "R6 pre after write", cyc - last_wr[b], E_RDL);
          act_ok_at[b] = cyc + E_RP;
        end
        4'b0100, 4'b0101: begin
          check(done == 1'b1, "R10 done with column", int'(done), 1);
          if (!col_seen[b]) check(cyc - last_act[b] == E_RCD, "R4 act-col delay", cyc - last_act[b], E_RCD);
          col_seen[b] = 1;
          if (addr[10]) begin
            pre_at = cyc + ((c == 4'b0100) ? E_RDL : 0);
            if (last_wr[b] + E_RDL > pre_at) pre_at = last_wr[b] + E_RDL;
            if (last_act[b] + E_RAS > pre_at) pre_at = last_act[b] + E_RAS;
            act_ok_at[b] = pre_at + E_RP;
          end
          if (c == 4'b0100) last_wr[b] = cyc;
        end
        default: ;
      endcase
    end else if (done) check(0, "R10 done without column", 1, 0);
  end

  task automatic do_req(input logic [1:0] b, input logic [11:0] r, input logic [8:0] col,
                        input bit w, input bit ap);
    logic [11:0] ca;
    ca = {1'b0, ap, 1'b0, col};
    if (m_open[b] && m_row[b] == r) begin
      exp_q.push_back('{w ? 4'b0100 : 4'b0101, b, ca});
    end else begin
      if (m_open[b]) exp_q.push_back('{4'b0010, b, 12'h000});
      exp_q.push_back('{4'b0011, b, r});
      exp_q.push_back('{w ? 4'b0100 : 4'b0101, b, ca});
    end
    m_open[b] = !ap;
    m_row[b]  = r;
    n_req++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_bank = b; req_row = r; req_col = col; req_write = w; req_autopre = ap;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, "R10 ready drops while busy", int'(req_ready), 0);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_row[i] = '0; last_act[i] = -1000; last_wr[i] = -1000;
      act_ok_at[i] = 0; col_seen[i] = 1;
    end
    exp_q.push_back('{4'b0000, 2'b00, MODE});
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 deselect in reset", int'(cs_n), 1);
    check(req_ready == 1'b0, "R1 ready low in reset", int'(req_ready), 0);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    rst_n = 1;
    do_req(2'd0, 12'h005, 9'h003, 1, 0);   // R4 idle bank write
    do_req(2'd0, 12'h005, 9'h007, 0, 0);   // R5 row hit
    do_req(2'd0, 12'h009, 9'h001, 0, 0);   // R6 row miss after write
    do_req(2'd1, 12'h002, 9'h1FF, 1, 1);   // R8 near act, R9 write with auto-precharge
    do_req(2'd1, 12'h002, 9'h004, 0, 0);   // R9 reopen without precharge
    do_req(2'd2, 12'hFFF, 9'h100, 0, 1);   // R9 read with auto-precharge
    do_req(2'd2, 12'hFFF, 9'h0AA, 0, 0);   // R7/R9 same bank reopen
    do_req(2'd3, 12'h007, 9'h010, 1, 0);
    do_req(2'd3, 12'h008, 9'h011, 1, 0);   // R6 miss right after write
    do_req(2'd0, 12'h009, 9'h002, 1, 0);   // R5 hit after other traffic
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected commands seen", exp_q.size(), 0);
    check(n_done == n_req, "R10 one done per request", n_done, n_req);
    finish_run();
  end
endmodule